// File: doc/BRIEF.md
# Hardware Breakpoint Comparator Unit

The unit holds four code-address breakpoints and compares every valid instruction fetch against them. When an enabled breakpoint equals the fetch address, it raises a halt request to the CPU halt logic on the next cycle. It also reports which breakpoint fired and records that the most recent halt came from a breakpoint rather than from a halt command.

Breakpoints are loaded over a byte-wide debug command channel. A set-breakpoint command is three bytes long. `cmd_start_i` marks the beginning of a command, and each byte is qualified by `cmd_valid_i`. The most significant byte goes first. Its top two bits select the breakpoint, and the bit below them is the enable. The last 18 bits of the command frame form the breakpoint address. The debug controller decodes which command it is; this unit only sees the payload of set-breakpoint commands. The controller also pulses `halt_cmd_i` when it halts the CPU by command, and that pulse clears the recorded cause.

Top module: `hw_bkpt_unit`

## Requirements
- R1: Four independent breakpoints, numbered 0 to 3, each hold a full 18-bit address. A fetch hits a breakpoint only when all 18 bits are equal.
- R2: Command frame layout. Byte 0 is the first byte sent. Its bits [7:6] are the breakpoint index, bit 5 is the enable, bits [4:2] are ignored, and bits [1:0] are address bits 17:16. Byte 1 carries address bits 15:8 and byte 2 carries bits 7:0. The breakpoint is written at the clock edge that accepts byte 2.
- R3: A command with enable 0 disables only the indexed breakpoint. The other three keep their address and enable.
- R4: `halt_req_o` is registered. It is high for exactly the cycle after each cycle in which a valid fetch hits an enabled breakpoint. Back-to-back hits keep it high.
- R5: A fetch address presented with `fetch_valid_i` low never causes a halt request.
- R6: When several enabled breakpoints hit at once, `match_idx_o` reports the lowest index among them.
- R7: `halt_cause_o` becomes 1 together with a breakpoint halt request. It becomes 0 the cycle after a `halt_cmd_i` pulse that has no breakpoint hit; a breakpoint hit in that same cycle wins. Otherwise it holds its value.
- R8: A `cmd_start_i` that arrives before byte 2 discards the bytes already received. The byte presented with the start, if any, is taken as a new byte 0.
- R9: Bytes received without a preceding start are ignored. This covers bytes after reset and bytes after a completed command, until the next `cmd_start_i`.
- R10: After reset, all breakpoints are disabled, `halt_req_o` and `halt_cause_o` are 0, and `match_idx_o` is 0.
- R11: `match_idx_o` changes only together with a halt request and otherwise holds the index of the last breakpoint that fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Start of a set-breakpoint command |
| cmd_valid_i | input | 1 | `cmd_byte_i` holds a command byte |
| cmd_byte_i | input | 8 | Command byte, first byte most significant |
| fetch_valid_i | input | 1 | CPU fetch address is valid this cycle |
| fetch_addr_i | input | 18 | CPU instruction fetch address |
| halt_cmd_i | input | 1 | CPU halted by debug command (pulse) |
| halt_req_o | output | 1 | Breakpoint halt request, registered |
| match_idx_o | output | 2 | Index of the breakpoint that fired last |
| halt_cause_o | output | 1 | 1: last halt from a breakpoint, 0: from a command |

## Verification
The assertions assume the following about the inputs:
- `halt_cmd_i` is a single-cycle pulse.
- A start is never immediately followed by a completed frame in the same cycle; the frame is longer than one byte.

The bench drives every input one clock cycle at a time, always on the falling edge. It issues halt commands only as isolated one-cycle pulses. It interleaves complete, truncated and unsolicited command bytes so that the frame counter passes through each of its states. Fetches that hit two breakpoints at once, and a halt command that coincides with a hit, are driven on purpose, because those are the cases where output priority matters.

// File: rtl/hw_bkpt_pkg.sv
package hw_bkpt_pkg;
  localparam int unsigned BP_NUM      = 4;
  localparam int unsigned BP_ADDR_W   = 18;
  localparam int unsigned BP_IDX_W    = $clog2(BP_NUM);
  localparam int unsigned CMD_BYTE_W  = 8;
  localparam int unsigned CMD_BYTES   = 3;
  localparam int unsigned CMD_FRAME_W = CMD_BYTES * CMD_BYTE_W;
  localparam int unsigned CMD_HEAD_W  = CMD_FRAME_W - CMD_BYTE_W;
  localparam int unsigned CMD_CNT_W   = $clog2(CMD_BYTES + 1);
  localparam int unsigned CMD_EN_POS  = CMD_FRAME_W - 1 - BP_IDX_W;

  typedef struct packed {
    logic [BP_IDX_W-1:0]  idx;
    logic                 en;
    logic [BP_ADDR_W-1:0] addr;
  } bp_wr_t;
endpackage

// File: rtl/hw_bkpt_cmd_rx.sv
module hw_bkpt_cmd_rx
  import hw_bkpt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  valid_i,
  input  logic [CMD_BYTE_W-1:0] byte_i,
  output logic                  wr_valid_o,
  output bp_wr_t                wr_o
);
  localparam logic [CMD_CNT_W-1:0] CntIdle = CMD_CNT_W'(CMD_BYTES);
  localparam logic [CMD_CNT_W-1:0] CntLast = CMD_CNT_W'(CMD_BYTES - 1);

  logic [CMD_CNT_W-1:0]   cnt_q, cnt_eff;
  logic [CMD_HEAD_W-1:0]  head_q;
  logic [CMD_FRAME_W-1:0] frame;
  logic                   take;
  logic                   spare_unused;

  // a start restarts the frame, including any byte arriving with it
  assign cnt_eff = start_i ? '0 : cnt_q;
  assign take    = valid_i && (cnt_eff != CntIdle);
  assign frame   = {head_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CntIdle;
      head_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt_eff + 1'b1;
      head_q <= frame[CMD_HEAD_W-1:0];
    end else if (start_i) begin
      cnt_q  <= '0;
    end
  end

  assign wr_valid_o = take && (cnt_eff == CntLast);
  assign wr_o.idx   = frame[CMD_FRAME_W-1 -: BP_IDX_W];
  assign wr_o.en    = frame[CMD_EN_POS];
  assign wr_o.addr  = frame[BP_ADDR_W-1:0];

  assign spare_unused = ^frame[CMD_EN_POS-1:BP_ADDR_W];
endmodule

// File: rtl/hw_bkpt_table.sv
module hw_bkpt_table
  import hw_bkpt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  bp_wr_t               wr_i,
  input  logic                 fetch_valid_i,
  input  logic [BP_ADDR_W-1:0] fetch_addr_i,
  output logic [BP_NUM-1:0]    hit_o
);
  for (genvar g = 0; g < BP_NUM; g++) begin : g_bp
    logic                 en_q;
    logic [BP_ADDR_W-1:0] addr_q;
    logic                 sel;

    assign sel = wr_valid_i && (wr_i.idx == BP_IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        addr_q <= '0;
      end else if (sel) begin
        en_q   <= wr_i.en;
        addr_q <= wr_i.addr;
      end
    end

    assign hit_o[g] = en_q && fetch_valid_i && (addr_q == fetch_addr_i);
  end
endmodule

// File: rtl/hw_bkpt_halt.sv
module hw_bkpt_halt
  import hw_bkpt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BP_NUM-1:0]   hit_i,
  input  logic                halt_cmd_i,
  output logic                halt_req_o,
  output logic [BP_IDX_W-1:0] match_idx_o,
  output logic                halt_cause_o
);
  logic                any_hit;
  logic [BP_IDX_W-1:0] first_idx;

  // lowest index wins
  always_comb begin
    first_idx = '0;
    for (int i = BP_NUM - 1; i >= 0; i--) begin
      if (hit_i[i]) first_idx = BP_IDX_W'(i);
    end
  end

  assign any_hit = |hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_req_o   <= 1'b0;
      match_idx_o  <= '0;
      halt_cause_o <= 1'b0;
    end else begin
      halt_req_o <= any_hit;
      if (any_hit) begin
        match_idx_o  <= first_idx;
        halt_cause_o <= 1'b1;
      end else if (halt_cmd_i) begin
        halt_cause_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hw_bkpt_unit.sv
module hw_bkpt_unit
  import hw_bkpt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_start_i,
  input  logic                  cmd_valid_i,
  input  logic [CMD_BYTE_W-1:0] cmd_byte_i,
  input  logic                  fetch_valid_i,
  input  logic [BP_ADDR_W-1:0]  fetch_addr_i,
  input  logic                  halt_cmd_i,
  output logic                  halt_req_o,
  output logic [BP_IDX_W-1:0]   match_idx_o,
  output logic                  halt_cause_o
);
  logic              bp_wr_valid;
  bp_wr_t            bp_wr;
  logic [BP_NUM-1:0] bp_hit;

  hw_bkpt_cmd_rx i_cmd_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cmd_start_i),
    .valid_i    (cmd_valid_i),
    .byte_i     (cmd_byte_i),
    .wr_valid_o (bp_wr_valid),
    .wr_o       (bp_wr)
  );

  hw_bkpt_table i_table (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_valid_i    (bp_wr_valid),
    .wr_i          (bp_wr),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .hit_o         (bp_hit)
  );

  hw_bkpt_halt i_halt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (bp_hit),
    .halt_cmd_i   (halt_cmd_i),
    .halt_req_o   (halt_req_o),
    .match_idx_o  (match_idx_o),
    .halt_cause_o (halt_cause_o)
  );
endmodule

// File: rtl/hw_bkpt_unit_chk.sv
module hw_bkpt_unit_chk
  import hw_bkpt_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_start_i,
  input logic                fetch_valid_i,
  input logic                halt_cmd_i,
  input logic                halt_req_o,
  input logic [BP_IDX_W-1:0] match_idx_o,
  input logic                halt_cause_o,
  input logic                bp_wr_valid,
  input logic [BP_NUM-1:0]   bp_hit
);
  // R4
  req_follows_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bp_hit) |=> halt_req_o);

  // R5
  no_halt_without_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !halt_req_o);

  // R7
  cause_set_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> halt_cause_o);

  // R7
  cause_clear_on_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_cmd_i && !fetch_valid_i) |=> !halt_cause_o);

  // R7
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(halt_cmd_i) && !halt_req_o) |-> $stable(halt_cause_o));

  // R11
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_req_o |-> $stable(match_idx_o));

  // R8
  no_write_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_i |-> !bp_wr_valid);

  // R9
  no_write_twice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_wr_valid |=> !bp_wr_valid);
endmodule

bind hw_bkpt_unit hw_bkpt_unit_chk i_chk (.*);

// File: tb/test_hw_bkpt_unit.sv
module test_hw_bkpt_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_start_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_byte_i = '0;
  logic        fetch_valid_i = 1'b0;
  logic [17:0] fetch_addr_i = '0;
  logic        halt_cmd_i = 1'b0;
  logic        halt_req_o;
  logic [1:0]  match_idx_o;
  logic        halt_cause_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic        m_en [4];
  logic [17:0] m_addr [4];
  logic [1:0]  m_idx;
  logic        m_cause;

  always #10 clk_i = ~clk_i;

  hw_bkpt_unit i_hw_bkpt_unit (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_raw(bit st, logic [7:0] b);
    @(negedge clk_i);
    cmd_start_i = st; cmd_valid_i = 1'b1; cmd_byte_i = b;
    @(negedge clk_i);
    cmd_start_i = 1'b0; cmd_valid_i = 1'b0;
  endtask

  // R2: byte0 = {idx[1:0], en, 3'b0, addr[17:16]}
  function automatic logic [7:0] hdr(logic [1:0] idx, logic en, logic [17:0] a);
    return {idx, en, 3'b000, a[17:16]};
  endfunction

  task automatic send_cmd(logic [1:0] idx, logic en, logic [17:0] a);
    @(negedge clk_i);
    cmd_start_i = 1'b1; cmd_valid_i = 1'b1; cmd_byte_i = hdr(idx, en, a);
    @(negedge clk_i);
    cmd_start_i = 1'b0; cmd_byte_i = a[15:8];
    @(negedge clk_i);
    cmd_byte_i = a[7:0];
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    m_en[idx] = en; m_addr[idx] = a;
  endtask

  task automatic fetch(string req, logic [17:0] a, bit vld, bit hc);
    bit hit = 1'b0;
    logic [1:0] first = '0;
    for (int i = 3; i >= 0; i--)
      if (vld && m_en[i] && m_addr[i] == a) begin hit = 1'b1; first = 2'(i); end
    @(negedge clk_i);
    fetch_valid_i = vld; fetch_addr_i = a; halt_cmd_i = hc;
    @(negedge clk_i);
    fetch_valid_i = 1'b0; halt_cmd_i = 1'b0;
    if (hit) begin m_idx = first; m_cause = 1'b1; end
    else if (hc) m_cause = 1'b0;
    chk({req, " halt_req"}, int'(halt_req_o), int'(hit));
    chk({req, " match_idx"}, int'(match_idx_o), int'(m_idx));
    chk({req, " halt_cause"}, int'(halt_cause_o), int'(m_cause));
  endtask

  task automatic t_reset;
    chk("R10 halt_req", int'(halt_req_o), 0);
    chk("R10 match_idx", int'(match_idx_o), 0);
    chk("R10 halt_cause", int'(halt_cause_o), 0);
    fetch("R10 all disabled", 18'h00000, 1'b1, 1'b0);
    // R9: stray frame enabling bp0 at 0x00000 without start
    send_raw(1'b0, hdr(2'd0, 1'b1, 18'h0));
    send_raw(1'b0, 8'h00);
    send_raw(1'b0, 8'h00);
    fetch("R9 stray after reset", 18'h00000, 1'b1, 1'b0);
  endtask

  task automatic t_load;
    send_cmd(2'd0, 1'b1, 18'h3FFFF);
    send_cmd(2'd1, 1'b1, 18'h2A5A5);
    send_cmd(2'd2, 1'b1, 18'h15A5A);
    send_cmd(2'd3, 1'b1, 18'h00001);
    fetch("R1 R2 bp2", 18'h15A5A, 1'b1, 1'b0);
    fetch("R1 R2 bp0", 18'h3FFFF, 1'b1, 1'b0);
    fetch("R1 R2 bp3", 18'h00001, 1'b1, 1'b0);
    fetch("R1 R2 bp1", 18'h2A5A5, 1'b1, 1'b0);
    fetch("R1 bit17 miss", 18'h1FFFF, 1'b1, 1'b0);
    fetch("R1 bit0 miss", 18'h15A5B, 1'b1, 1'b0);
    fetch("R5 invalid fetch", 18'h3FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_timing;
    // R4: registered output, back-to-back hits hold it high
    @(negedge clk_i);
    fetch_valid_i = 1'b1; fetch_addr_i = 18'h00001;
    #1 chk("R4 not same cycle", int'(halt_req_o), 0);
    @(negedge clk_i);
    fetch_addr_i = 18'h3FFFF;
    chk("R4 first hit", int'(halt_req_o), 1);
    chk("R4 idx first", int'(match_idx_o), 3);
    @(negedge clk_i);
    fetch_valid_i = 1'b0;
    chk("R4 second hit", int'(halt_req_o), 1);
    chk("R4 idx second", int'(match_idx_o), 0);
    @(negedge clk_i);
    chk("R4 drop", int'(halt_req_o), 0);
    m_idx = 2'd0;
  endtask

  task automatic t_priority;
    send_cmd(2'd3, 1'b1, 18'h2A5A5);
    fetch("R6 lowest of 1,3", 18'h2A5A5, 1'b1, 1'b0);
    send_cmd(2'd1, 1'b0, 18'h2A5A5);
    fetch("R3 disabled bp1 -> bp3", 18'h2A5A5, 1'b1, 1'b0);
    fetch("R3 bp0 unchanged", 18'h3FFFF, 1'b1, 1'b0);
    fetch("R3 bp2 unchanged", 18'h15A5A, 1'b1, 1'b0);
  endtask

  task automatic t_cause;
    fetch("R7 halt cmd clears", 18'h00000, 1'b1, 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R7 cause holds", int'(halt_cause_o), 0);
    chk("R11 idx holds", int'(match_idx_o), int'(m_idx));
    fetch("R7 bp sets cause", 18'h3FFFF, 1'b1, 1'b0);
    fetch("R7 cmd clears again", 18'h11111, 1'b1, 1'b1);
    fetch("R7 bp wins over cmd", 18'h15A5A, 1'b1, 1'b1);
  endtask

  task automatic t_partial;
    // R8: truncated bp2 command, then full bp0 command
    send_raw(1'b1, hdr(2'd2, 1'b1, 18'h01234));
    send_raw(1'b0, 8'h12);
    send_cmd(2'd0, 1'b1, 18'h00F0F);
    fetch("R8 bp2 kept old", 18'h15A5A, 1'b1, 1'b0);
    fetch("R8 partial not loaded", 18'h01234, 1'b1, 1'b0);
    fetch("R8 new bp0", 18'h00F0F, 1'b1, 1'b0);
    // R9: bytes after a completed command, trying to disable bp2
    send_raw(1'b0, hdr(2'd2, 1'b0, 18'h0));
    send_raw(1'b0, 8'h00);
    send_raw(1'b0, 8'h00);
    fetch("R9 trailing bytes ignored", 18'h15A5A, 1'b1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_en[i] = 1'b0; m_addr[i] = '0; end
    m_idx = '0; m_cause = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_timing();
    t_priority();
    t_cause();
    t_partial();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule